// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block gives a hart two timer comparators for the levels below machine mode. One is for the supervisor level and one is for the virtual-supervisor (guest) level. Each has a 64-bit compare register. Each register is checked against the shared 64-bit time bus that already feeds the machine timer. While the time value is at or past the compare value, the matching pending output stays high. Software arms a timer tick with a single register write and needs no round trip through machine-mode firmware.

Two enable bits decide who may use the facility. One is owned by machine mode and one by the hypervisor. When an enable is clear, three things change. Accesses to the compare registers from lower modes fault. The pending outputs stop following the comparators. Each pending output then follows a software-written bit instead. Machine mode is never blocked. A virtualized supervisor always reaches the guest compare register, whatever register it selects.

Top module: `stimer_cmp`

## Requirements
- R1: After reset both compare registers read as all ones, and both pending outputs are 0.
- R2: With the machine enable set, `stip_o` equals (time ≥ supervisor compare), one clock after the time or compare value changes. It stays high for as long as the condition holds.
- R3: The comparison is unsigned over the full 64 bits. A compare value with bit 63 set is not reached by a time value with bit 63 clear.
- R4: With both enables set, `vstip_o` equals (time ≥ guest compare) with the same timing, independent of the supervisor compare register.
- R5: With the machine enable clear, `stip_o` follows the software pending bit. Software writes that bit through `pend_we_i[0]`/`pend_wd_i[0]`, and `stip_o` follows it one clock after the write takes effect. The comparator result is ignored.
- R6: With either enable clear, `vstip_o` follows the software bit written through `pend_we_i[1]`/`pend_wd_i[1]`.
- R7: While an output is comparator-driven, software pending writes do not change it.
- R8: `priv_i` encoding: 0 = user, 1 = supervisor, 3 = machine, 2 = reserved. Machine-mode accesses never fault. User-mode and reserved-mode accesses always raise `illegal_o`.
- R9: A supervisor access with `virt_i`=0 selects a register through `csr_sel_i` (0 = supervisor compare, 1 = guest compare). It raises `illegal_o` when the machine enable is clear.
- R10: A supervisor access with `virt_i`=1 targets the guest compare register whatever `csr_sel_i` is. It raises `illegal_o` when the machine enable is clear. It raises `vfault_o` when the machine enable is set and the hypervisor enable is clear. The two faults never occur together.
- R11: A faulting access writes nothing and drives `csr_rdata_o` to 0.
- R12: A permitted access reads the target register on `csr_rdata_o` in the same cycle. A write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Shared time value |
| priv_i | input | 2 | Privilege of the access (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Access comes from a virtualized mode |
| m_en_i | input | 1 | Machine-level enable |
| h_en_i | input | 1 | Hypervisor-level enable |
| csr_valid_i | input | 1 | Compare register access this cycle |
| csr_write_i | input | 1 | Access is a write |
| csr_sel_i | input | 1 | 0 supervisor compare, 1 guest compare |
| csr_wdata_i | input | 64 | Write data |
| pend_we_i | input | 2 | Software pending write strobes (bit 0 S, bit 1 VS) |
| pend_wd_i | input | 2 | Software pending write values |
| csr_rdata_o | output | 64 | Read data, 0 on fault |
| illegal_o | output | 1 | Illegal-instruction fault |
| vfault_o | output | 1 | Virtual-instruction fault |
| stip_o | output | 1 | Supervisor timer pending |
| vstip_o | output | 1 | Guest timer pending |

## Verification
The bench sweeps time around several compare values: zero, mid-range, the sign-bit boundary and near the top. A signed comparator would fail at the sign-bit boundary. An off-by-one comparator (strict greater-than) would fail at equality. It then walks all 64 combinations of privilege, virtualization, both enables and register select. Each combination is a write followed by machine-mode readback. This catches a fault decode that ignores an enable, a write that lands despite a fault, and a guest access that is not redirected. The enable-off tests toggle the software pending bits while the comparator says the opposite. An output wired to the wrong source shows up there.

// File: rtl/stimer_cmp.sv
module stimer_cmp #(
  parameter int TW    = 64,
  parameter bit HAS_H = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_i,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic          m_en_i,
  input  logic          h_en_i,
  input  logic          csr_valid_i,
  input  logic          csr_write_i,
  input  logic          csr_sel_i,
  input  logic [TW-1:0] csr_wdata_i,
  input  logic [1:0]    pend_we_i,
  input  logic [1:0]    pend_wd_i,
  output logic [TW-1:0] csr_rdata_o,
  output logic          illegal_o,
  output logic          vfault_o,
  output logic          stip_o,
  output logic          vstip_o
);
  logic [TW-1:0] s_cmp_q, vs_cmp_q;
  logic sw_s_q, sw_vs_q, stip_q, vstip_q;

  wire is_m   = (priv_i == 2'b11);
  wire is_s   = (priv_i == 2'b01);
  wire tgt_vs = (is_s && virt_i) || csr_sel_i;

  assign illegal_o = csr_valid_i && !is_m &&
                     (!is_s || !m_en_i || (tgt_vs && !HAS_H));
  assign vfault_o  = csr_valid_i && HAS_H && is_s && virt_i && m_en_i && !h_en_i;

  wire acc_ok = csr_valid_i && !illegal_o && !vfault_o;
  wire wr_s   = acc_ok && csr_write_i && !tgt_vs;
  wire wr_vs  = acc_ok && csr_write_i && tgt_vs;

  assign csr_rdata_o = !acc_ok ? '0 : (tgt_vs ? vs_cmp_q : s_cmp_q);
  assign stip_o  = stip_q;
  assign vstip_o = vstip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cmp_q <= '1;
      sw_s_q  <= 1'b0;
      stip_q  <= 1'b0;
    end else begin
      if (wr_s) s_cmp_q <= csr_wdata_i;
      if (pend_we_i[0]) sw_s_q <= pend_wd_i[0];
      stip_q <= m_en_i ? (time_i >= s_cmp_q) : sw_s_q;
    end
  end

  generate
    if (HAS_H) begin : g_vs
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vs_cmp_q <= '1;
          sw_vs_q  <= 1'b0;
          vstip_q  <= 1'b0;
        end else begin
          if (wr_vs) vs_cmp_q <= csr_wdata_i;
          if (pend_we_i[1]) sw_vs_q <= pend_wd_i[1];
          vstip_q <= (m_en_i && h_en_i) ? (time_i >= vs_cmp_q) : sw_vs_q;
        end
      end
    end else begin : g_no_vs
      wire unused_vs = wr_vs ^ h_en_i ^ pend_we_i[1] ^ pend_wd_i[1];
      assign vs_cmp_q = '1;
      assign sw_vs_q  = unused_vs & 1'b0;
      assign vstip_q  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/stimer_cmp_chk.sv
module stimer_cmp_chk #(
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] time_i,
  input logic [1:0]    priv_i,
  input logic          virt_i,
  input logic          m_en_i,
  input logic          h_en_i,
  input logic          csr_valid_i,
  input logic          csr_write_i,
  input logic          illegal_o,
  input logic          vfault_o,
  input logic          stip_o,
  input logic          vstip_o,
  input logic [TW-1:0] s_cmp,
  input logic [TW-1:0] vs_cmp,
  input logic          sw_s,
  input logic          sw_vs
);
  AST_STIP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    m_en_i |=> stip_o == ($past(time_i) >= $past(s_cmp))); // R2
  AST_STIP_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    !m_en_i |=> stip_o == $past(sw_s)); // R5
  AST_VSTIP_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_en_i && h_en_i) |=> vstip_o == $past(sw_vs)); // R6
  AST_M_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid_i && priv_i == 2'b11) |-> !illegal_o && !vfault_o); // R8
  AST_VS_VIRT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid_i && priv_i == 2'b01 && virt_i && m_en_i && !h_en_i) |-> vfault_o); // R10
  AST_ONE_FAULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_o && vfault_o)); // R10
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid_i && csr_write_i && (illegal_o || vfault_o)) |=> $stable(s_cmp) && $stable(vs_cmp)); // R11
endmodule

bind stimer_cmp stimer_cmp_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .time_i(time_i), .priv_i(priv_i), .virt_i(virt_i),
  .m_en_i(m_en_i), .h_en_i(h_en_i), .csr_valid_i(csr_valid_i), .csr_write_i(csr_write_i),
  .illegal_o(illegal_o), .vfault_o(vfault_o), .stip_o(stip_o), .vstip_o(vstip_o),
  .s_cmp(s_cmp_q), .vs_cmp(vs_cmp_q), .sw_s(sw_s_q), .sw_vs(sw_vs_q)
);

// File: tb/stimer_cmp_tb_top.sv
module stimer_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_i = '0;
  logic [1:0]  priv = 2'b11;
  logic        virt = 1'b0, men = 1'b0, hen = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, sel = 1'b0;
  logic [63:0] wdata = '0;
  logic [1:0]  pwe = '0, pwd = '0;
  logic [63:0] rdata;
  logic        illegal, vfault, stip, vstip;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [63:0] es, ev, rb;
  localparam logic [63:0] CMPS [5] = '{64'd0, 64'd5, 64'h8000_0000_0000_0000,
                                       64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FFFF_FFF0};

  always #5 clk = ~clk;

  stimer_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .priv_i(priv), .virt_i(virt),
    .m_en_i(men), .h_en_i(hen), .csr_valid_i(valid), .csr_write_i(wr), .csr_sel_i(sel),
    .csr_wdata_i(wdata), .pend_we_i(pwe), .pend_wd_i(pwd), .csr_rdata_o(rdata),
    .illegal_o(illegal), .vfault_o(vfault), .stip_o(stip), .vstip_o(vstip)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_write(input logic s, input logic [63:0] d);
    priv = 2'b11; virt = 1'b0; sel = s; wdata = d; valid = 1'b1; wr = 1'b1;
    step();
    valid = 1'b0; wr = 1'b0;
  endtask

  task automatic m_read(input logic s, output logic [63:0] d);
    priv = 2'b11; virt = 1'b0; sel = s; valid = 1'b1; wr = 1'b0;
    #1 d = rdata;
    valid = 1'b0;
  endtask

  task automatic set_pend(input logic [1:0] v);
    pwe = 2'b11; pwd = v;
    step();
    pwe = 2'b00;
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    m_read(1'b0, rb); chk("R1 s_cmp reset", rb, '1);
    m_read(1'b1, rb); chk("R1 vs_cmp reset", rb, '1);
    chk("R1 stip reset", 64'(stip), 0);
    chk("R1 vstip reset", 64'(vstip), 0);

    men = 1'b1; hen = 1'b1;
    for (int ci = 0; ci < 5; ci++) begin
      m_write(1'b0, CMPS[ci]);
      m_write(1'b1, CMPS[ci] + 64'd3);
      for (int d = -2; d <= 2; d++) begin
        time_i = CMPS[ci] + 64'(d);
        step();
        chk("R2/R3 stip vs time", 64'(stip), 64'(time_i >= CMPS[ci]));
        chk("R4 vstip vs time", 64'(vstip), 64'(time_i >= CMPS[ci] + 64'd3));
      end
      repeat (3) step();
      chk("R2 stip held as level", 64'(stip), 1);
    end

    m_write(1'b0, 64'd100); m_write(1'b1, 64'd100);
    time_i = 64'd10;
    set_pend(2'b11);
    chk("R7 stip ignores sw bit", 64'(stip), 0);
    chk("R7 vstip ignores sw bit", 64'(vstip), 0);
    men = 1'b0;
    step();
    chk("R5 stip follows sw bit", 64'(stip), 1);
    chk("R6 vstip follows sw bit", 64'(vstip), 1);
    time_i = 64'd200;
    set_pend(2'b00);
    chk("R5 stip ignores comparator", 64'(stip), 0);
    chk("R6 vstip ignores comparator", 64'(vstip), 0);
    men = 1'b1; hen = 1'b0;
    step();
    chk("R2 stip back on comparator", 64'(stip), 1);
    chk("R6 vstip gated by h enable", 64'(vstip), 0);
    set_pend(2'b10);
    chk("R6 vstip sw set", 64'(vstip), 1);
    hen = 1'b1; time_i = '0;
    step();
    chk("R4 vstip back on comparator", 64'(vstip), 0);

    m_read(1'b0, es); m_read(1'b1, ev);
    for (int idx = 0; idx < 64; idx++) begin
      logic [1:0] p;
      logic v, m, h, s, tv, eill, evf;
      string tag;
      p = idx[5:4]; v = idx[3]; m = idx[2]; h = idx[1]; s = idx[0];
      tv   = (p == 2'd1 && v) || s;
      eill = (p != 2'd3) && (p != 2'd1 || !m);
      evf  = !eill && p == 2'd1 && v && !h;
      tag  = (p == 2'd1) ? (v ? "R10" : "R9") : "R8";
      men = m; hen = h; priv = p; virt = v; sel = s;
      wdata = 64'h5A00_0000_0000_0000 + 64'(idx * 7 + 1);
      valid = 1'b1; wr = 1'b1;
      #1;
      chk({tag, " illegal"}, 64'(illegal), 64'(eill));
      chk({tag, " vfault"}, 64'(vfault), 64'(evf));
      if (eill || evf) chk("R11 rdata zero on fault", rdata, 0);
      else chk("R12 read value", rdata, tv ? ev : es);
      step();
      valid = 1'b0; wr = 1'b0;
      if (!(eill || evf)) begin
        if (tv) ev = wdata; else es = wdata;
      end
      m_read(1'b0, rb); chk((eill || evf) ? "R11 s_cmp after" : "R12 s_cmp after", rb, es);
      m_read(1'b1, rb); chk((eill || evf) ? "R11 vs_cmp after" : "R12 vs_cmp after", rb, ev);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule